// File: doc/BRIEF.md
# EOI Interrupt Storm Throttle

This block sits next to an interrupt redirection engine and watches every end-of-interrupt (EOI) event that the engine resolves. For each EOI it gets the vector and one flag. The flag says whether the level-triggered source behind that vector is unmasked and still asserted, which means the engine would re-deliver it at once. The block keeps a small counter per vector of such back-to-back immediate re-deliveries. While the counter stays under a threshold, the EOI produces a "serve now" strobe. When the count reaches the threshold, the counter drops back to zero and the block arms a one-shot delay. When that delay expires, a "serve after delay" strobe asks the engine to rescan all of its pins. A handler that never quiets its source therefore still lets the system make slow progress.

The counters live in a RAM indexed by vector, with one EOI accepted per clock cycle. A per-vector "written since reset" bit makes every counter read as zero after reset without a clearing sweep. Reads and writes go through a two-stage read-modify-write with forwarding, so EOIs for the same vector may arrive on consecutive cycles. The delay is a cycle count, by default equal to 10 ms at the given clock rate. Arming the delay while it is already running leaves its expiry time unchanged.

Top module: `eoi_storm_throttle`

## Requirements
- R1: After reset both outputs are low, every vector's counter reads as zero and the delay timer is idle. A reset in the middle of a count discards it.
- R2: An EOI with `eoi_pending` high whose incremented count stays below `STORM_LIMIT` gives a one-cycle `serve_now` pulse in the second cycle after the EOI cycle.
- R3: Each pending EOI adds one to its vector's counter. The pending EOI that brings the count to `STORM_LIMIT` gives no `serve_now`, sets the counter to zero and arms the delay, so the next `STORM_LIMIT-1` pending EOIs for that vector are served at once again.
- R4: An EOI with `eoi_pending` low gives no `serve_now` and resets that vector's counter to zero.
- R5: Once armed, `serve_delayed` pulses for exactly one cycle, `DELAY_CYCLES` cycles after the cycle in which `serve_now` would have pulsed for the arming EOI.
- R6: Arming while the delay is already running keeps the earlier expiry and adds no extra `serve_delayed` pulse.
- R7: Counters are kept per vector. EOIs on one vector never change the count of another.
- R8: One EOI is accepted every cycle, including EOIs for the same vector on consecutive cycles, with no lost or stale count.
- R9: A cycle with `eoi_valid` low has no effect, whatever `eoi_vector` and `eoi_pending` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eoi_valid | input | 1 | An EOI is presented this cycle |
| eoi_vector | input | $clog2(NUM_VECTORS) | Vector of the EOI |
| eoi_pending | input | 1 | Source is unmasked and still asserted, so it would be re-delivered |
| serve_now | output | 1 | Re-serve immediately (one-cycle strobe) |
| serve_delayed | output | 1 | Delay expired: rescan all pins (one-cycle strobe) |

## Verification
The bench drives the counter to the threshold on a single vector with gaps between EOIs, and also back to back on consecutive cycles. A design without forwarding would read a stale count on the back-to-back run and throttle too late. A non-pending EOI in the middle of a run must restart the count; a design that only held the count would throttle early. Two vectors are interleaved to catch shared or misindexed counters. A second arm while the delay is running must not move or duplicate the expiry pulse. A reset in the middle of a count must make the next threshold need a full run again.

// File: rtl/eoi_throttle_pkg.sv
package eoi_throttle_pkg;
  typedef enum logic [1:0] {
    DEC_NONE  = 2'd0,
    DEC_NOW   = 2'd1,
    DEC_DEFER = 2'd2
  } eoi_dec_e;
endpackage

// File: rtl/storm_count_ram.sv
module storm_count_ram #(
  parameter int DEPTH = 256,
  parameter int DW    = 14,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  // simple dual port, read-first, registered read: maps to block RAM
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/storm_timer.sv
module storm_timer #(
  parameter int DELAY_CYCLES = 1000000,
  localparam int TW = $clog2(DELAY_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  output logic fire
);
  logic          armed;
  logic [TW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed  <= 1'b0;
      remain <= '0;
      fire   <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (armed) begin
        // an arm request while running is dropped: expiry stays put
        if (remain == '0) begin
          armed <= 1'b0;
          fire  <= 1'b1;
        end else begin
          remain <= remain - 1'b1;
        end
      end else if (arm) begin
        armed  <= 1'b1;
        remain <= TW'(DELAY_CYCLES - 1);
      end
    end
  end

  AST_FIRE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire); // R5
  AST_REMAIN_BOUND: assert property (@(posedge clk) disable iff (rst)
    armed |-> (remain < TW'(DELAY_CYCLES))); // R5
  AST_ARM_KEEPS_EXPIRY: assert property (@(posedge clk) disable iff (rst)
    (armed && remain != '0) |=> (armed && remain == $past(remain) - 1'b1)); // R6
endmodule

// File: rtl/eoi_storm_throttle.sv
module eoi_storm_throttle
  import eoi_throttle_pkg::*;
#(
  parameter int NUM_VECTORS  = 256,
  parameter int CNT_W        = 14,
  parameter int STORM_LIMIT  = 10000,
  parameter int CLK_HZ       = 100000000,
  parameter int DELAY_US     = 10000,
  parameter int DELAY_CYCLES = (CLK_HZ / 1000000) * DELAY_US,
  localparam int VEC_W       = $clog2(NUM_VECTORS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             eoi_valid,
  input  logic [VEC_W-1:0] eoi_vector,
  input  logic             eoi_pending,
  output logic             serve_now,
  output logic             serve_delayed
);
  localparam logic [CNT_W:0] LIMIT_V = (CNT_W + 1)'(STORM_LIMIT);

  // stage 1: EOI captured, counter read in flight
  logic             s1_valid;
  logic [VEC_W-1:0] s1_vec;
  logic             s1_pend;
  logic             seen_rd;
  logic [NUM_VECTORS-1:0] seen;
  logic [CNT_W-1:0] ram_rd;

  // write port of the current cycle and its registered copy for forwarding
  logic             wr_en;
  logic [CNT_W-1:0] wr_val;
  logic             fw_en;
  logic [VEC_W-1:0] fw_vec;
  logic [CNT_W-1:0] fw_val;

  logic [CNT_W-1:0] cur;
  logic [CNT_W:0]   inc;
  eoi_dec_e         dec;
  logic             arm;

  storm_count_ram #(.DEPTH(NUM_VECTORS), .DW(CNT_W)) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr (s1_vec),
    .wdata (wr_val),
    .raddr (eoi_vector),
    .rdata (ram_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_vec   <= '0;
      s1_pend  <= 1'b0;
      seen_rd  <= 1'b0;
      seen     <= '0;
      fw_en    <= 1'b0;
      fw_vec   <= '0;
      fw_val   <= '0;
    end else begin
      s1_valid <= eoi_valid;
      s1_vec   <= eoi_vector;
      s1_pend  <= eoi_pending;
      seen_rd  <= seen[eoi_vector];
      if (wr_en) seen[s1_vec] <= 1'b1;
      fw_en  <= wr_en;
      fw_vec <= s1_vec;
      fw_val <= wr_val;
    end
  end

  always_comb begin
    if (fw_en && fw_vec == s1_vec) cur = fw_val;
    else if (seen_rd)              cur = ram_rd;
    else                           cur = '0;
    inc = {1'b0, cur} + 1'b1;
    if (!s1_pend) begin
      dec    = DEC_NONE;
      wr_val = '0;
    end else if (inc >= LIMIT_V) begin
      dec    = DEC_DEFER;
      wr_val = '0;
    end else begin
      dec    = DEC_NOW;
      wr_val = inc[CNT_W-1:0];
    end
    wr_en = s1_valid;
    arm   = s1_valid && (dec == DEC_DEFER);
  end

  always_ff @(posedge clk) begin
    if (rst) serve_now <= 1'b0;
    else     serve_now <= s1_valid && (dec == DEC_NOW);
  end

  storm_timer #(.DELAY_CYCLES(DELAY_CYCLES)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .arm  (arm),
    .fire (serve_delayed)
  );

  AST_NOW_NEEDS_EOI: assert property (@(posedge clk) disable iff (rst)
    serve_now |-> ($past(eoi_valid, 2) && $past(eoi_pending, 2))); // R2
  AST_NONPEND_NO_SERVE: assert property (@(posedge clk) disable iff (rst)
    ($past(eoi_valid, 2) && !$past(eoi_pending, 2)) |-> !serve_now); // R4
  AST_IDLE_NO_SERVE: assert property (@(posedge clk) disable iff (rst)
    !$past(eoi_valid, 2) |-> !serve_now); // R9
  AST_COUNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ({1'b0, wr_val} < LIMIT_V)); // R3
endmodule

// File: tb/sim_eoi_storm_throttle.sv
module sim_eoi_storm_throttle;
  localparam int CLK_PERIOD = 10;
  localparam int NV  = 16;
  localparam int VW  = 4;
  localparam int LIM = 4;
  localparam int DLY = 20;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic          rst;
  logic          eoi_valid;
  logic [VW-1:0] eoi_vector;
  logic          eoi_pending;
  logic          serve_now;
  logic          serve_delayed;

  eoi_storm_throttle #(
    .NUM_VECTORS(NV), .CNT_W(6), .STORM_LIMIT(LIM), .DELAY_CYCLES(DLY)
  ) u0 (
    .clk(clk), .rst(rst), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .eoi_pending(eoi_pending), .serve_now(serve_now), .serve_delayed(serve_delayed)
  );

  int    errors = 0;
  int    checks = 0;
  int    cyc = 0;
  int    fire_at = -1;
  int    cnt_m [NV];
  bit    exp_q [$];
  string tag_q [$];
  bit    done = 1'b0;

  // monitor: pop the expectation due this cycle and compare
  task automatic monitor_cycle();
    bit    e;
    bit    ed;
    string t;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    checks++;
    if (serve_now !== e) begin
      errors++;
      $display("FAIL %s serve_now cycle %0d got %0b exp %0b", t, cyc, serve_now, e);
    end
    ed = (cyc == fire_at);
    checks++;
    if (serve_delayed !== ed) begin
      errors++;
      $display("FAIL R5 serve_delayed cycle %0d got %0b exp %0b", cyc, serve_delayed, ed);
    end
    if (ed) fire_at = -1;
  endtask

  // driver: model the requirement, queue the expectation, drive inputs
  task automatic step(input bit v, input int vec, input bit pend, input string tag);
    bit e;
    @(negedge clk);
    monitor_cycle();
    e = 1'b0;
    if (v) begin
      if (!pend) cnt_m[vec] = 0;                       // R4
      else if (cnt_m[vec] + 1 >= LIM) begin            // R3
        cnt_m[vec] = 0;
        if (fire_at < cyc + 2) fire_at = cyc + 2 + DLY; // R5, R6
      end else begin
        cnt_m[vec]++;
        e = 1'b1;                                      // R2
      end
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
    eoi_valid   = v;
    eoi_vector  = VW'(vec);
    eoi_pending = pend;
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, (i * 7) % NV, i[0], "R9");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    eoi_valid = 1'b0; eoi_vector = '0; eoi_pending = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      checks++;
      if (serve_now !== 1'b0 || serve_delayed !== 1'b0) begin
        errors++;
        $display("FAIL R1 reset outputs got %0b%0b exp 00", serve_now, serve_delayed);
      end
    end
    rst = 1'b0;
    for (int i = 0; i < NV; i++) cnt_m[i] = 0;
    exp_q.delete(); tag_q.delete();
    for (int i = 0; i < 2; i++) begin exp_q.push_back(1'b0); tag_q.push_back("R1"); end
    fire_at = -1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R2 / R3: spaced EOIs on one vector up to the threshold
    step(1, 5, 1, "R2"); step(0, 5, 1, "R9");
    step(1, 5, 1, "R2"); step(1, 5, 1, "R2");
    step(1, 5, 1, "R3");
    idle(26);
    step(1, 5, 1, "R3");
    idle(3);
    // R4: non-pending EOI restarts the count
    step(1, 7, 1, "R4"); step(1, 7, 1, "R4"); step(1, 7, 0, "R4");
    step(1, 7, 1, "R4"); step(1, 7, 1, "R4"); step(1, 7, 1, "R4");
    step(1, 7, 1, "R4");
    idle(26);
    // R8 / R6: back-to-back same vector, second arm while running
    for (int i = 0; i < 8; i++) step(1, 9, 1, "R8");
    idle(30);
    // R7: interleaved vectors back to back
    for (int i = 0; i < 8; i++) step(1, 1 + (i % 2), 1, "R7");
    idle(30);
    // R1: reset in the middle of a count
    step(1, 3, 1, "R1"); step(1, 3, 1, "R1");
    idle(2);
    do_reset();
    for (int i = 0; i < 4; i++) step(1, 3, 1, "R1");
    idle(30);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule